// File: doc/BRIEF.md
# Triggered Multi-Channel Pulse Sequencer

The sequencer plays back stored pulse programs on a set of analog sample channels, 32 by default. Every channel owns a small segment memory. A segment holds a shape code, a duration in ticks and a 16-bit target amplitude. The memory is divided into experiment regions. A host writes segments through a simple write port while the sequencer is idle.

The run-select input chooses an experiment region. A rising edge on the external trigger then starts all channels in the same cycle. The trigger is synchronised inside the block. Each clock cycle is one time tick, 10 ns at 100 MHz. On every tick of a run, each channel emits one sample word with a valid strobe for a downstream converter link.

A run always lasts a fixed number of ticks, at most 5,000,000 (50 ms). After that tick every channel returns to idle and a completion flag rises.

Top module: `pulse_seq_top`

## Requirements
- R1: The trigger input passes through a two-stage synchroniser. A rising edge of the synchronised trigger starts a run only while the block is idle. Take the rising clock edge at which trig_i is first sampled high. The first valid sample appears on the fourth rising edge after that one.
- R2: A run gives exactly MAX_RUN ticks of valid samples. busy_o is high from the start edge up to the edge that emits the last sample. done_o rises on that edge and stays high until the next run starts. When valid is low, every sample output is zero.
- R3: Trigger edges that arrive during a run do not change the run. A trigger still held high after a run ends starts no new run.
- R4: Shape code 0 (flat) outputs the segment amplitude on every tick of the segment.
- R5: Shape code 1 (ramp) outputs a value on tick t (counting from 0) of a segment lasting D ticks. For a rising ramp the value is B + floor((A-B)(t+1)/D). For a falling ramp it is B - floor((B-A)(t+1)/D). A is the segment amplitude. B is the previous segment's amplitude, or 0 for the first segment.
- R6: Shape codes 2 and 3 (end marker) output zero for the rest of the run. The channel does not advance past the marker.
- R7: A stored duration of 0 lasts one tick. Any other duration D lasts D ticks. After the last segment index, playback wraps to index 0 of the same experiment.
- R8: Playback reads only the experiment region chosen by exp_sel_i, sampled on the start edge.
- R9: A write while the block is busy, or in its start cycle, is discarded and sets wr_err_o. Only reset clears wr_err_o. An idle write is stored and does not set the flag.
- R10: Each channel plays its own segment list. All channels assert valid on the same ticks.
- R11: After reset, busy_o, done_o, wr_err_o, every valid bit and every sample are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Asynchronous run trigger |
| exp_sel_i | input | EXP_W | Experiment region for the next run |
| wr_en_i | input | 1 | Segment write strobe |
| wr_ch_i | input | CH_W | Channel to write |
| wr_exp_i | input | EXP_W | Experiment region to write |
| wr_seg_i | input | SEG_W | Segment index to write |
| wr_shape_i | input | 2 | Shape code: 0 flat, 1 ramp, 2/3 end |
| wr_dur_i | input | DUR_W | Duration in ticks (0 means 1) |
| wr_amp_i | input | AMP_W | Target amplitude |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run reached its tick limit |
| wr_err_o | output | 1 | Sticky flag for a rejected write |
| sample_o | output | NUM_CH*AMP_W | Sample words; channel n in bits n*AMP_W upward |
| valid_o | output | NUM_CH | Per-channel sample strobe |

## Verification
The bench targets these corner cases:
- **Zero durations.** A design that let a zero duration stall, or run for 2^DUR_W ticks, would shift every later sample.
- **Ramps in both directions.** A wrong rounding or a wrong base would show up on intermediate ticks, while the end points still match.
- **End markers and index wrap.** A design that ran past a marker or wrapped into the other experiment region would give wrong values.

Runs are started with triggers pulsed and held during the run. A design that restarted, stretched the run or re-armed would give the wrong valid count or a second run. One write is placed inside a run. The next run uses the same program, so a write that was not rejected would show up in the samples. The first-sample latency and the done and busy edges are checked on the exact tick.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [1:0] {
    SH_FLAT    = 2'd0,
    SH_RAMP    = 2'd1,
    SH_END     = 2'd2,
    SH_END_ALT = 2'd3
  } shape_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRIME = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/pseq_trig_sync.sv
module pseq_trig_sync (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= trig_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;

  // R1: an edge pulse lasts exactly one cycle
  p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pseq_run_ctrl.sv
module pseq_run_ctrl
  import pseq_pkg::*;
#(
  parameter int MAX_RUN = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  output logic start_o,
  output logic prime_o,
  output logic run_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int RUN_W = $clog2(MAX_RUN + 1);
  localparam logic [RUN_W-1:0] LAST_TICK = RUN_W'(MAX_RUN - 1);

  phase_e           phase_q;
  logic [RUN_W-1:0] tick_q;
  logic             done_q;

  assign start_o = rise_i && (phase_q == PH_IDLE);
  assign prime_o = (phase_q == PH_PRIME);
  assign run_o   = (phase_q == PH_RUN);
  assign last_o  = run_o && (tick_q == LAST_TICK);
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      tick_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_o) begin
            phase_q <= PH_PRIME;
            tick_q  <= '0;
            done_q  <= 1'b0;
          end
        end
        PH_PRIME: phase_q <= PH_RUN;
        PH_RUN: begin
          if (last_o) begin
            phase_q <= PH_IDLE;
            tick_q  <= '0;
            done_q  <= 1'b1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R2: the tick counter never reaches the cap value itself
  p_tick_bound_r2: assert property (@(posedge clk) disable iff (rst)
    tick_q < RUN_W'(MAX_RUN));

  // R3: mid-run triggers neither restart nor stall the tick count
  p_tick_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run_o && !last_o) |=> (run_o && tick_q == $past(tick_q) + 1'b1));

  // R2: the last tick ends the run and raises done
  p_done_after_cap_r2: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (done_o && !busy_o));

  // R1: a run only begins from a synchronised rising edge
  p_start_from_edge_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(rise_i));
endmodule

// File: rtl/pseq_seg_mem.sv
module pseq_seg_mem #(
  parameter int AW = 6,
  parameter int DW = 34
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) ram[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= ram[raddr_i];
  end
endmodule

// File: rtl/pseq_channel.sv
module pseq_channel
  import pseq_pkg::*;
#(
  parameter int AMP_W = 16,
  parameter int DUR_W = 16,
  parameter int SEG_W = 5,
  parameter int EXP_W = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   prime_i,
  input  logic                   run_i,
  input  logic [EXP_W-1:0]       exp_i,
  input  logic                   we_i,
  input  logic [EXP_W+SEG_W-1:0] waddr_i,
  input  logic [2+DUR_W+AMP_W-1:0] wdata_i,
  output logic [AMP_W-1:0]       sample_o,
  output logic                   valid_o
);
  localparam int AW = EXP_W + SEG_W;
  localparam int DW = 2 + DUR_W + AMP_W;
  localparam int MW = AMP_W + DUR_W + 1;

  logic [DW-1:0]    nxt_word;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;

  shape_e           cur_shape;
  logic [DUR_W-1:0] cur_dur;
  logic [AMP_W-1:0] cur_amp;
  logic [AMP_W-1:0] base_q;
  logic [DUR_W-1:0] pos_q;
  logic [SEG_W-1:0] fetch_q;
  logic [EXP_W-1:0] exp_q;

  logic [DUR_W-1:0] dur_eff;
  logic             at_end, last_pos, advance;
  logic [AMP_W-1:0] level, mag;
  logic             rising;
  logic [MW-1:0]    prod, quo;

  pseq_seg_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk     (clk),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .re_i    (rd_en),
    .raddr_i (rd_addr),
    .rdata_o (nxt_word)
  );

  assign dur_eff  = (cur_dur == '0) ? DUR_W'(1) : cur_dur;
  assign at_end   = cur_shape[1];
  assign last_pos = (pos_q == dur_eff - 1'b1);
  assign advance  = run_i && last_pos && !at_end;

  assign rd_en   = start_i || prime_i || advance;
  assign rd_addr = start_i ? {exp_i, {SEG_W{1'b0}}} : {exp_q, fetch_q};

  // ramp value: base moved by floor(|amp-base|*(pos+1)/dur)
  assign rising = (cur_amp >= base_q);
  assign mag    = rising ? (cur_amp - base_q) : (base_q - cur_amp);
  assign prod   = MW'(mag) * (MW'(pos_q) + MW'(1));
  assign quo    = prod / MW'(dur_eff);

  always_comb begin
    case (cur_shape)
      SH_FLAT: level = cur_amp;
      SH_RAMP: level = rising ? (base_q + quo[AMP_W-1:0])
                              : (base_q - quo[AMP_W-1:0]);
      default: level = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_shape <= SH_END;
      cur_dur   <= '0;
      cur_amp   <= '0;
      base_q    <= '0;
      pos_q     <= '0;
      fetch_q   <= '0;
      exp_q     <= '0;
      sample_o  <= '0;
      valid_o   <= 1'b0;
    end else begin
      if (start_i) begin
        exp_q   <= exp_i;
        fetch_q <= SEG_W'(1);
      end
      if (prime_i || advance) begin
        cur_shape <= shape_e'(nxt_word[DW-1 -: 2]);
        cur_dur   <= nxt_word[AMP_W +: DUR_W];
        cur_amp   <= nxt_word[AMP_W-1:0];
        base_q    <= prime_i ? '0 : level;
        pos_q     <= '0;
        fetch_q   <= fetch_q + 1'b1;
      end else if (run_i && !at_end) begin
        pos_q <= pos_q + 1'b1;
      end
      sample_o <= run_i ? level : '0;
      valid_o  <= run_i;
    end
  end

  // R7: the position inside a segment stays below its effective length
  p_pos_bound_r7: assert property (@(posedge clk) disable iff (rst)
    pos_q < dur_eff);

  // R4: a flat segment emits its amplitude
  p_flat_level_r4: assert property (@(posedge clk) disable iff (rst)
    (run_i && cur_shape == SH_FLAT) |=> (sample_o == $past(cur_amp)));

  // R5: a ramp lands on its amplitude on its final tick
  p_ramp_lands_r5: assert property (@(posedge clk) disable iff (rst)
    (run_i && cur_shape == SH_RAMP && last_pos) |=> (sample_o == $past(cur_amp)));

  // R6: an end marker emits zero
  p_end_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (run_i && at_end) |=> (sample_o == '0));

  // R2: samples are zero whenever the strobe is low
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (sample_o == '0));
endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top
  import pseq_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int AMP_W   = 16,
  parameter int DUR_W   = 16,
  parameter int SEG_W   = 5,
  parameter int EXP_W   = 1,
  parameter int MAX_RUN = 5_000_000,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig_i,
  input  logic [EXP_W-1:0]        exp_sel_i,
  input  logic                    wr_en_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic [EXP_W-1:0]        wr_exp_i,
  input  logic [SEG_W-1:0]        wr_seg_i,
  input  logic [1:0]              wr_shape_i,
  input  logic [DUR_W-1:0]        wr_dur_i,
  input  logic [AMP_W-1:0]        wr_amp_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    wr_err_o,
  output logic [NUM_CH*AMP_W-1:0] sample_o,
  output logic [NUM_CH-1:0]       valid_o
);
  localparam int DW = 2 + DUR_W + AMP_W;

  logic rise, start, prime, run, last;
  logic wr_ok, wr_bad, err_q;
  logic [DW-1:0]          wr_word;
  logic [EXP_W+SEG_W-1:0] wr_addr;

  pseq_trig_sync sync_i (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  pseq_run_ctrl #(.MAX_RUN(MAX_RUN)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (rise),
    .start_o (start),
    .prime_o (prime),
    .run_o   (run),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign wr_ok   = wr_en_i && !busy_o && !start;
  assign wr_bad  = wr_en_i && !wr_ok;
  assign wr_word = {wr_shape_i, wr_dur_i, wr_amp_i};
  assign wr_addr = {wr_exp_i, wr_seg_i};

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (wr_bad) err_q <= 1'b1;
  end
  assign wr_err_o = err_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_we;
    assign ch_we = wr_ok && (wr_ch_i == CH_W'(g));
    pseq_channel #(
      .AMP_W(AMP_W), .DUR_W(DUR_W), .SEG_W(SEG_W), .EXP_W(EXP_W)
    ) chan_i (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start),
      .prime_i  (prime),
      .run_i    (run),
      .exp_i    (exp_sel_i),
      .we_i     (ch_we),
      .waddr_i  (wr_addr),
      .wdata_i  (wr_word),
      .sample_o (sample_o[g*AMP_W +: AMP_W]),
      .valid_o  (valid_o[g])
    );
  end

  // R9: the error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    wr_err_o |=> wr_err_o);

  // R9: a write during a run is flagged
  p_busy_write_flagged_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && busy_o) |=> wr_err_o);

  // R10: all channels strobe together
  p_lockstep_r10: assert property (@(posedge clk) disable iff (rst)
    (valid_o == '0) || (valid_o == '1));

  // R2: samples are valid only inside a run or on its closing tick
  p_valid_in_run_r2: assert property (@(posedge clk) disable iff (rst)
    valid_o[0] |-> (busy_o || $rose(done_o)));
endmodule

// File: tb/pulse_seq_top_tb_top.sv
`timescale 1ns/1ps
module pulse_seq_top_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int SW  = 3;
  localparam int EW  = 1;
  localparam int MR  = 40;
  localparam int DEP = 1 << SW;
  localparam int CW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic [EW-1:0] exp_sel = '0;
  logic wr_en = 1'b0;
  logic [CW-1:0] wr_ch = '0;
  logic [EW-1:0] wr_exp = '0;
  logic [SW-1:0] wr_seg = '0;
  logic [1:0] wr_shape = '0;
  logic [DW-1:0] wr_dur = '0;
  logic [AW-1:0] wr_amp = '0;
  logic busy, done, wr_err;
  logic [NCH*AW-1:0] sample;
  logic [NCH-1:0] valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int m_shape [NCH][2][DEP];
  int m_dur   [NCH][2][DEP];
  int m_amp   [NCH][2][DEP];

  always #4 clk = ~clk;

  pulse_seq_top #(
    .NUM_CH(NCH), .AMP_W(AW), .DUR_W(DW), .SEG_W(SW), .EXP_W(EW), .MAX_RUN(MR)
  ) dut_i (
    .clk(clk), .rst(rst), .trig_i(trig), .exp_sel_i(exp_sel),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_exp_i(wr_exp), .wr_seg_i(wr_seg),
    .wr_shape_i(wr_shape), .wr_dur_i(wr_dur), .wr_amp_i(wr_amp),
    .busy_o(busy), .done_o(done), .wr_err_o(wr_err),
    .sample_o(sample), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // arithmetic model of one channel's sample on run tick k
  function automatic int model(int c, int e, int k);
    int base = 0;
    int idx = 0;
    int t = k;
    forever begin
      int sh = m_shape[c][e][idx];
      int d = (m_dur[c][e][idx] == 0) ? 1 : m_dur[c][e][idx];
      int a = m_amp[c][e][idx];
      if (sh >= 2) return 0;
      if (t < d) begin
        if (sh == 0) return a;
        if (a >= base) return base + int'((longint'(a - base) * (t + 1)) / d);
        return base - int'((longint'(base - a) * (t + 1)) / d);
      end
      base = a;
      t = t - d;
      idx = (idx + 1) % DEP;
    end
  endfunction

  task automatic write_seg(int c, int e, int s, int sh, int d, int a);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CW'(c); wr_exp = EW'(e); wr_seg = SW'(s);
    wr_shape = 2'(sh); wr_dur = DW'(d); wr_amp = AW'(a);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(int pat);
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < NCH; c++)
        for (int s = 0; s < DEP; s++) begin
          int sh, d, a;
          sh = ((s * 3 + c + e + pat) % 5 == 4) ? (2 + ((s + pat) % 2))
                                                : ((s + c + e + pat) % 2);
          d  = (s * 5 + c * 3 + e * 7 + pat * 2) % 9;
          a  = (s * 12345 + c * 4321 + e * 999 + pat * 3131 + 77) % 65536;
          m_shape[c][e][s] = sh; m_dur[c][e][s] = d; m_amp[c][e][s] = a;
          write_seg(c, e, s, sh, d, a);
        end
  endtask

  task automatic do_run(int e, bit mid_trig, bit mid_wr, bit hold);
    int first;
    trig = 1'b0;
    repeat (4) @(negedge clk);
    exp_sel = EW'(e);
    @(negedge clk);
    trig = 1'b1;
    first = -1;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      if (valid != '0) begin first = n; break; end
    end
    // R1: first sample on the fourth edge after trig_i is first sampled
    chk(first == 5, "R1 first-sample latency", first, 5);
    if (first != 5) return;
    for (int k = 0; k < MR; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 13) wr_en = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        int exp_v = model(c, e, k);
        int act_v = int'(sample[c*AW +: AW]);
        // checks R4 R5 R6 R7 R8 R10 through the per-tick model
        chk(act_v == exp_v, $sformatf("R4/R5 R6 R7 R8 R10 ch%0d tick%0d", c, k), act_v, exp_v);
      end
      chk(valid == '1, "R10 all strobes", valid, 15);
      if (k < MR - 1) chk(busy && !done, "R2 busy inside run", {busy, done}, 2);
      else            chk(!busy && done, "R2 done on last tick", {busy, done}, 1);
      if (k == 5 && !hold) trig = 1'b0;
      if (mid_trig && k == 10) trig = 1'b1;   // R3 retrigger during run
      if (mid_trig && k == 14) trig = 1'b0;
      if (mid_trig && k == 20) trig = 1'b1;
      if (mid_wr && k == 12) begin             // R9 write during run
        wr_en = 1'b1; wr_ch = '0; wr_exp = EW'(e); wr_seg = '0;
        wr_shape = 2'd0; wr_dur = DW'(1); wr_amp = AW'(12345);
      end
    end
    @(negedge clk);
    chk(valid == '0 && sample == '0, "R2 idle after cap", valid, 0);
    chk(done && !busy, "R2 done holds", {busy, done}, 1);
    begin
      bit quiet = 1;
      repeat (12) begin
        @(negedge clk);
        if (valid != '0 || busy) quiet = 0;
      end
      chk(quiet, "R3 no restart after run", quiet, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !wr_err, "R11 flags", {busy, done, wr_err}, 0);
    chk(valid == '0 && sample == '0, "R11 outputs", valid, 0);

    prog(0);
    chk(!wr_err, "R9 idle writes accepted", wr_err, 0);
    do_run(0, 1, 1, 0);
    chk(wr_err, "R9 run write flagged", wr_err, 1);
    // rerun proves the rejected write left memory untouched (R9)
    do_run(0, 0, 0, 0);
    do_run(1, 0, 0, 1);
    write_seg(0, 0, 0, m_shape[0][0][0], m_dur[0][0][0], m_amp[0][0][0]);
    chk(wr_err, "R9 flag sticky", wr_err, 1);
    for (int p = 1; p <= 2; p++) begin
      prog(p);
      for (int e = 0; e < 2; e++) do_run(e, 0, 0, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule